// File: doc/BRIEF.md
# Locked Fixed-Priority Bus Arbiter

This block decides which of several masters owns a shared system bus. Each master has a request line and a lock line. The arbiter drives a one-hot grant vector. Master 0 has the highest priority. When nobody requests the bus, a default master (master 3, the lowest priority) keeps it, and that master never needs to raise a request.

The grant moves only at a handover point. A handover point is a cycle in which the slave wait input is low and the transaction-type field does not announce a sequential burst continuation. While the owning master holds its lock line, the next transfer is indivisible and the grant stays where it is. A lock raised by any master that does not own the bus is ignored.

Requests, locks, wait and transaction type are registered on one rising edge. The grant reacts on the following edge, so the grant output never changes in the same edge that samples the inputs behind it.

Top module: `lockprio_arb`

## Requirements
- R1: While rst_n is low at a rising edge, the grant becomes 4'b1000 (default master 3) from that edge on.
- R2: The grant is exactly one-hot in every cycle after reset.
- R3: At a handover point with no owner lock, the grant goes to the lowest-numbered master whose request bit is set.
- R4: At a handover point with no owner lock and no request bit set, the grant goes to the default master (4'b1000).
- R5: A cycle whose sampled wait_i is high is not a handover point, and the grant does not change after it.
- R6: ttype_i encodes 2'b00 address-only, 2'b01 nonsequential, 2'b10 sequential and 2'b11 reserved. With wait_i low, 2'b10 is not a handover point and the grant does not change. The codes 2'b00, 2'b01 and 2'b11 are handover points.
- R7: If lock_i of the current grant holder is sampled high at a handover point, the grant does not change, even when higher-priority requests are present. Once that lock is released, the grant moves as usual.
- R8: lock_i bits of masters that do not hold the grant have no effect on the grant.
- R9: If the owner drops its request at an unlocked handover point, the grant goes to the lowest-numbered remaining requester, or to master 3 if there is none.
- R10: An input change applied between edges reaches gnt_o on the second rising edge after it, not on the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 4 | Per-master bus request, bit i for master i |
| lock_i | input | 4 | Per-master lock: the next transfer is indivisible |
| wait_i | input | 1 | Slave wait: high means the current transfer does not complete |
| ttype_i | input | 2 | Type of the next transaction (00 address-only, 01 nonsequential, 10 sequential, 11 reserved) |
| gnt_o | output | 4 | One-hot grant, bit i for master i |

## Verification
Embedded properties check on every cycle that the grant is one-hot. They also check that it stays put after a wait cycle, after a sequential-type cycle and after a cycle in which the owner holds its lock. A further property compares the priority picker with a lowest-set-bit formula, and another checks that it falls back to the default master. Only the bench scenarios show the two-edge latency, the reset value, and the fact that a lock from a non-owner has no effect. They also show the full outcome of each request and lock pattern from each starting owner, and that reserved and address-only types count as handover points.

// File: rtl/arb_pkg.sv
// Shared types for the locked priority arbiter.
// Assumes a 2-bit transaction-type field; only the sequential code blocks a handover.
package arb_pkg;

    typedef enum logic [1:0] {
        TT_ADDR = 2'b00,
        TT_NSEQ = 2'b01,
        TT_SEQ  = 2'b10,
        TT_RSVD = 2'b11
    } ttype_e;

    // True when the cycle closes a transfer and does not continue a burst.
    function automatic logic is_handover(input logic wait_in, input logic [1:0] tt);
        return (!wait_in) && (tt != TT_SEQ);
    endfunction

endpackage

// File: rtl/arb_in_stage.sv
// Input register stage: captures requests, locks and the handover condition
// on one edge so the grant logic acts on them at the next edge.
// Assumes inputs are synchronous to clk.
module arb_in_stage #(
    parameter int N_MST = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_MST-1:0] req_i,
    input  logic [N_MST-1:0] lock_i,
    input  logic             wait_i,
    input  logic [1:0]       ttype_i,
    output logic [N_MST-1:0] req_q,
    output logic [N_MST-1:0] lock_q,
    output logic             bnd_q
);
    import arb_pkg::*;

    // Register all arbitration inputs; reset clears them and blocks handover.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= '0;
            lock_q <= '0;
            bnd_q  <= 1'b0;
        end else begin
            req_q  <= req_i;
            lock_q <= lock_i;
            bnd_q  <= is_handover(wait_i, ttype_i);
        end
    end

endmodule

// File: rtl/arb_prio_pick.sv
// Fixed-priority picker: the lowest-numbered set request wins; with no
// request the default master is chosen. Purely combinational.
// Assumes DEF_MST < N_MST.
module arb_prio_pick #(
    parameter int N_MST   = 4,
    parameter int DEF_MST = 3
) (
    input  logic [N_MST-1:0] req,
    output logic [N_MST-1:0] pick
);
    localparam logic [N_MST-1:0] DEF_OH = N_MST'(1) << DEF_MST;

    logic [N_MST:0]   seen;
    logic [N_MST-1:0] win;

    assign seen[0] = 1'b0;

    // Ripple a "higher-priority request seen" chain across the masters.
    for (genvar i = 0; i < N_MST; i++) begin : g_chain
        assign win[i]    = req[i] & ~seen[i];
        assign seen[i+1] = seen[i] | req[i];
    end

    // Fall back to the default master when nobody requests.
    assign pick = seen[N_MST] ? win : DEF_OH;

endmodule

// File: rtl/arb_grant_state.sv
// Grant register: loads the picker result at an unlocked handover point and
// holds otherwise. The owner's lock is the only lock that counts.
// Assumes pick is one-hot.
module arb_grant_state #(
    parameter int N_MST   = 4,
    parameter int DEF_MST = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bnd_q,
    input  logic [N_MST-1:0] lock_q,
    input  logic [N_MST-1:0] pick,
    output logic [N_MST-1:0] gnt_q
);
    localparam logic [N_MST-1:0] DEF_OH = N_MST'(1) << DEF_MST;

    logic owner_locked;
    logic take;

    // Only the lock bit of the grant holder can freeze the grant.
    assign owner_locked = |(lock_q & gnt_q);
    assign take         = bnd_q & ~owner_locked;

    // Hold the grant; reload it only at an unlocked handover point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_q <= DEF_OH;
        end else if (take) begin
            gnt_q <= pick;
        end
    end

    // R2: exactly one master owns the bus
    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(gnt_q));

    // R5 / R6: no handover point, no grant movement
    p_hold_nobnd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bnd_q |=> $stable(gnt_q));

    // R7: owner lock freezes the grant
    p_lock_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_q && |(lock_q & gnt_q)) |=> $stable(gnt_q));

endmodule

// File: rtl/lockprio_arb.sv
// Locked fixed-priority bus arbiter top. Inputs are registered, a priority
// picker selects the winner, and the grant register moves only at unlocked
// handover points. Master 0 has the highest priority; DEF_MST is the default owner.
// Assumes synchronous inputs and a synchronous active-low reset.
module lockprio_arb #(
    parameter int N_MST   = 4,
    parameter int DEF_MST = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_MST-1:0] req_i,
    input  logic [N_MST-1:0] lock_i,
    input  logic             wait_i,
    input  logic [1:0]       ttype_i,
    output logic [N_MST-1:0] gnt_o
);
    localparam logic [N_MST-1:0] DEF_OH = N_MST'(1) << DEF_MST;

    logic [N_MST-1:0] req_q;
    logic [N_MST-1:0] lock_q;
    logic             bnd_q;
    logic [N_MST-1:0] pick;

    arb_in_stage #(.N_MST(N_MST)) u_in (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_i),
        .lock_i  (lock_i),
        .wait_i  (wait_i),
        .ttype_i (ttype_i),
        .req_q   (req_q),
        .lock_q  (lock_q),
        .bnd_q   (bnd_q)
    );

    arb_prio_pick #(.N_MST(N_MST), .DEF_MST(DEF_MST)) u_pick (
        .req  (req_q),
        .pick (pick)
    );

    arb_grant_state #(.N_MST(N_MST), .DEF_MST(DEF_MST)) u_gnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .bnd_q  (bnd_q),
        .lock_q (lock_q),
        .pick   (pick),
        .gnt_q  (gnt_o)
    );

    // R3: picker result equals the lowest set request bit
    p_pick_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_q) |-> (pick == (req_q & (~req_q + N_MST'(1)))));

    // R4: no request selects the default master
    p_pick_def_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q == '0) |-> (pick == DEF_OH));

endmodule

// File: tb/tb_lockprio_arb.sv
module tb_lockprio_arb;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] req_i;
    logic [3:0] lock_i;
    logic       wait_i;
    logic [1:0] ttype_i;
    logic [3:0] gnt_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    lockprio_arb dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .lock_i(lock_i),
        .wait_i(wait_i), .ttype_i(ttype_i), .gnt_o(gnt_o)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s actual=%b expected=%b", tag, got, exp);
        end
    endtask

    task automatic check_oh(input logic [3:0] got);
        n_chk++;
        if ($countones(got) != 1) begin
            n_err++;
            $display("FAIL R2 actual=%b expected=one-hot", got);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(input logic [3:0] r, input logic [3:0] l,
                         input logic w, input logic [1:0] t);
        req_i = r; lock_i = l; wait_i = w; ttype_i = t;
    endtask

    task automatic set_owner(input int m);
        drive(4'(1 << m), 4'b0000, 1'b0, 2'b01);
        step(2);
        check("R3", gnt_o, 4'(1 << m));
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive(4'b0001, 4'b0000, 1'b0, 2'b01);
        step(3);
        check("R1", gnt_o, 4'b1000);
        rst_n = 1'b1;
        drive(4'b0000, 4'b0000, 1'b1, 2'b01);
        step(1);
        check("R1", gnt_o, 4'b1000);

        // Sweep every owner, request pattern and lock pattern.
        for (int o = 0; o < 4; o++) begin
            for (int r = 0; r < 16; r++) begin
                for (int l = 0; l < 16; l++) begin
                    logic [3:0] rv, lv, ex;
                    string tag;
                    rv = 4'(r); lv = 4'(l);
                    set_owner(o);
                    drive(rv, lv, 1'b0, 2'b01);
                    step(2);
                    if (lv[o])             begin ex = 4'(1 << o);    tag = "R7"; end
                    else if (rv == 4'b0)   begin ex = 4'b1000;       tag = "R4"; end
                    else begin
                        ex = rv & (~rv + 4'd1);
                        if (lv != 4'b0)    tag = "R8";
                        else if (!rv[o])   tag = "R9";
                        else               tag = "R3";
                    end
                    check(tag, gnt_o, ex);
                    check_oh(gnt_o);
                end
            end
        end

        // R5: wait high blocks handover, release lets it happen
        set_owner(3);
        drive(4'b0001, 4'b0000, 1'b1, 2'b01);
        step(3);
        check("R5", gnt_o, 4'b1000);
        wait_i = 1'b0;
        step(2);
        check("R5", gnt_o, 4'b0001);

        // R6: sequential type blocks handover; address-only and reserved do not
        set_owner(3);
        drive(4'b0010, 4'b0000, 1'b0, 2'b10);
        step(3);
        check("R6", gnt_o, 4'b1000);
        ttype_i = 2'b00;
        step(2);
        check("R6", gnt_o, 4'b0010);
        set_owner(3);
        drive(4'b0100, 4'b0000, 1'b0, 2'b11);
        step(2);
        check("R6", gnt_o, 4'b0100);

        // R7: lock held then released
        set_owner(1);
        drive(4'b0001, 4'b0010, 1'b0, 2'b01);
        step(3);
        check("R7", gnt_o, 4'b0010);
        lock_i = 4'b0000;
        step(2);
        check("R7", gnt_o, 4'b0001);

        // R10: two-edge latency
        set_owner(3);
        drive(4'b0001, 4'b0000, 1'b0, 2'b01);
        step(1);
        check("R10", gnt_o, 4'b1000);
        step(1);
        check("R10", gnt_o, 4'b0001);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule